// File: doc/BRIEF.md
# PWM Timer with Fault Protection

This block is a down-counting PWM timer with a fault-protection stage in front of its counter and its output pin. Six raw fault sources feed it: a comparator result, three external fault pins, a flag that reports a failed system clock, and a trigger from the event fabric. Each source has its own enable and its own polarity. Each source also has a digital glitch filter whose length is set by a shared input. The enabled, filtered sources are ORed into one fault condition.

When the fault condition starts, the counter follows one selectable entry behaviour. When it ends, the counter follows one selectable exit behaviour. While it lasts, the PWM pin follows one selectable output behaviour. These three selections are independent of each other. An active clock-failure source always releases the pin to high impedance, whatever output behaviour is selected. All configuration arrives on static input ports. The block has no data stream and no handshake: every pin is a plain level.

Top module: `pwm_fault_timer`

## Requirements
- R1: While `rst_n` is low, `count_out` is 0, `pwm_out` is 0, `pwm_oe` is 1 and `fault_active` is 0.
- R2: Outside a fault, the counter steps down by one on each clock. From 0 it reloads `load_val`. After every clock, `pwm_out` is 1 exactly when `count_out < cmp_val`.
- R3: Source bit positions in `src_enable` and `src_polarity` are: bit 0 comparator, bits 1 to 3 external pins 0 to 2, bit 4 clock failure, bit 5 event trigger. A source whose enable bit is 0 has no effect on `fault_active`, on the counter or on the output.
- R4: When its polarity bit is 1, a source is active-low. When its polarity bit is 0, it is active-high.
- R5: A source changes its filtered state only after its polarity-corrected level has been sampled unchanged for `filt_len`+1 consecutive clocks. Shorter pulses are discarded. `fault_active` rises `filt_len`+3 clocks after an accepted change at the raw pin.
- R6: On the first clock of a fault and for as long as it lasts, the counter follows `entry_mode`: 0 holds the count, 1 keeps counting down until it reaches 0 and then holds 0, 2 keeps counting normally with reload.
- R7: On the first clock after the fault ends, the counter follows `exit_mode`: 0 loads `load_val`, 1 loads 0, 2 steps down normally from the value it held.
- R8: While `fault_active` is 1, the pin follows `out_mode`: 0 drives 1, 1 drives 0, 2 inverts the pre-fault level once and holds it, 3 sets `pwm_oe` to 0, 4 keeps the normal PWM level. Codes 5 to 7 behave as 4. Unless R9 applies, `pwm_oe` stays 1 in modes 0, 1, 2 and 4.
- R9: While an enabled clock-failure source is part of the fault, `pwm_oe` is 0 in every output mode.
- R10: `fault_active` falls, and normal PWM output resumes, on the clock after the last clock with an active filtered source. A fault that lasts a single filtered clock still applies both its entry and its exit behaviour.
- R11: The fault condition is the OR of all enabled sources. It persists while any one of them is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmp_in | input | 1 | Comparator fault source |
| ext_fault_in | input | 3 | External fault pins |
| clkfail_in | input | 1 | System clock failure flag |
| evt_trig_in | input | 1 | Event fabric fault trigger |
| src_enable | input | 6 | Per-source enable |
| src_polarity | input | 6 | Per-source polarity, 1 = active-low |
| filt_len | input | FLT_W | Filter length minus one |
| load_val | input | CNT_W | Counter reload value |
| cmp_val | input | CNT_W | PWM compare value |
| entry_mode | input | 2 | Counter behaviour during a fault |
| exit_mode | input | 2 | Counter behaviour when a fault ends |
| out_mode | input | 3 | Pin behaviour during a fault |
| count_out | output | CNT_W | Current count |
| pwm_out | output | 1 | PWM pin level |
| pwm_oe | output | 1 | Pin drive enable, 0 = high impedance |
| fault_active | output | 1 | Registered fault condition |

## Verification
The bench builds the block with the default 8-bit counter and a 3-bit filter length. It runs with a reload value of 9 and a compare value of 4. These values let a fault begin at several different counts and let the run-to-zero entry behaviour reach its floor within a dozen clocks. Filter lengths of 0 and 3 bring within reach a fault that lasts exactly one filtered clock, a pulse one clock short of acceptance, and the exact latency from pin to `fault_active`.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int unsigned NSRC    = 6;
  localparam int unsigned SRC_CLK = 4;

  typedef enum logic [1:0] {
    ENT_HALT  = 2'd0,
    ENT_DRAIN = 2'd1,
    ENT_RUN   = 2'd2
  } entry_e;

  typedef enum logic [1:0] {
    EXT_RELOAD = 2'd0,
    EXT_ZERO   = 2'd1,
    EXT_RESUME = 2'd2
  } exit_e;

  typedef enum logic [2:0] {
    OUT_HIGH = 3'd0,
    OUT_LOW  = 3'd1,
    OUT_FLIP = 3'd2,
    OUT_HIZ  = 3'd3,
    OUT_PWM  = 3'd4
  } outm_e;
endpackage

// File: rtl/pft_glitch_filter.sv
module pft_glitch_filter #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic             invert_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             level_o
);
  logic             samp_q;
  logic             level_q;
  logic [LEN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      level_q <= 1'b0;
      run_q   <= '0;
    end else begin
      samp_q <= raw_i ^ invert_i;
      if (samp_q != level_q) begin
        if (run_q == len_i) begin
          level_q <= samp_q;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_o = level_q;

  // R5: a level is accepted once the run of equal samples reaches the limit
  assert_filter_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_q != level_q && run_q == len_i) |=> level_q == $past(samp_q));

  // R5: with no disagreement the filtered level cannot move
  assert_filter_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_q == level_q) |=> $stable(level_q));
endmodule

// File: rtl/pft_counter.sv
module pft_counter
  import pft_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_i,
  input  logic             flt_i,
  input  logic             flt_q_i,
  input  entry_e           entry_i,
  input  exit_e            exit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wrap_c;
  logic [CNT_W-1:0] nxt_c;
  logic             leaving_c;

  assign wrap_c    = (cnt_q == '0) ? load_i : cnt_q - 1'b1;
  assign leaving_c = !flt_i && flt_q_i;

  always_comb begin
    nxt_c = wrap_c;
    if (leaving_c) begin
      case (exit_i)
        EXT_RELOAD: nxt_c = load_i;
        EXT_ZERO:   nxt_c = '0;
        default:    nxt_c = wrap_c;
      endcase
    end else if (flt_i) begin
      case (entry_i)
        ENT_HALT:  nxt_c = cnt_q;
        ENT_DRAIN: nxt_c = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
        default:   nxt_c = wrap_c;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_c;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = nxt_c;

  // R2: plain counting reloads after zero
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_i && !flt_q_i && cnt_q == '0) |=> cnt_q == $past(load_i));

  // R6: halt entry freezes the count
  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_i && entry_i == ENT_HALT) |=> cnt_q == $past(cnt_q));

  // R6: drain entry never leaves zero
  assert_drain_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_i && entry_i == ENT_DRAIN && cnt_q == '0) |=> cnt_q == '0);

  // R7: zero exit clears the count
  assert_exit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_i && flt_q_i && exit_i == EXT_ZERO) |=> cnt_q == '0);
endmodule

// File: rtl/pft_out_stage.sv
module pft_out_stage
  import pft_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             flt_i,
  input  logic             flt_q_i,
  input  logic             clk_flt_i,
  input  outm_e            mode_i,
  output logic             pwm_o,
  output logic             oe_o
);
  logic pwm_q;
  logic oe_q;
  logic level_c;
  logic pwm_d;
  logic oe_d;

  assign level_c = (cnt_nxt_i < cmp_i);

  always_comb begin
    pwm_d = level_c;
    oe_d  = 1'b1;
    if (flt_i) begin
      case (mode_i)
        OUT_HIGH: pwm_d = 1'b1;
        OUT_LOW:  pwm_d = 1'b0;
        OUT_FLIP: pwm_d = flt_q_i ? pwm_q : ~pwm_q;
        OUT_HIZ: begin
          pwm_d = pwm_q;
          oe_d  = 1'b0;
        end
        default:  pwm_d = level_c;
      endcase
      if (clk_flt_i) oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      pwm_q <= pwm_d;
      oe_q  <= oe_d;
    end
  end

  assign pwm_o = pwm_q;
  assign oe_o  = oe_q;

  // R9: clock failure always releases the pin
  assert_clk_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_i && clk_flt_i) |=> !oe_q);

  // R8: forced-high mode drives one
  assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_i && mode_i == OUT_HIGH) |=> pwm_q);

  // R8: toggle mode holds its level after entry
  assert_flip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_i && flt_q_i && mode_i == OUT_FLIP) |=> $stable(pwm_q));

  // R10: no fault means the pin is driven
  assert_drive_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_i) |=> oe_q);
endmodule

// File: rtl/pwm_fault_timer.sv
module pwm_fault_timer
  import pft_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned FLT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  input  logic [2:0]       ext_fault_in,
  input  logic             clkfail_in,
  input  logic             evt_trig_in,
  input  logic [5:0]       src_enable,
  input  logic [5:0]       src_polarity,
  input  logic [FLT_W-1:0] filt_len,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       entry_mode,
  input  logic [1:0]       exit_mode,
  input  logic [2:0]       out_mode,
  output logic [CNT_W-1:0] count_out,
  output logic             pwm_out,
  output logic             pwm_oe,
  output logic             fault_active
);
  logic [NSRC-1:0]  raw_v;
  logic [NSRC-1:0]  filt_v;
  logic [NSRC-1:0]  live_v;
  logic             fault_now;
  logic             fault_q;
  logic [CNT_W-1:0] cnt_nxt;
  outm_e            out_sel;

  assign raw_v = {evt_trig_in, clkfail_in, ext_fault_in, cmp_in};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pft_glitch_filter #(.LEN_W(FLT_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (raw_v[g]),
      .invert_i (src_polarity[g]),
      .len_i    (filt_len),
      .level_o  (filt_v[g])
    );
  end

  assign live_v    = filt_v & src_enable;
  assign fault_now = |live_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_now;
  end

  assign out_sel = (out_mode > 3'd4) ? OUT_PWM : outm_e'(out_mode);

  pft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_val),
    .flt_i     (fault_now),
    .flt_q_i   (fault_q),
    .entry_i   (entry_e'(entry_mode)),
    .exit_i    (exit_e'(exit_mode)),
    .cnt_o     (count_out),
    .cnt_nxt_o (cnt_nxt)
  );

  pft_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_nxt_i (cnt_nxt),
    .cmp_i     (cmp_val),
    .flt_i     (fault_now),
    .flt_q_i   (fault_q),
    .clk_flt_i (live_v[SRC_CLK]),
    .mode_i    (out_sel),
    .pwm_o     (pwm_out),
    .oe_o      (pwm_oe)
  );

  assign fault_active = fault_q;

  // R3: with every source disabled no fault can be raised
  assert_all_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_enable == '0) |=> !fault_active);

  // R11: an enabled filtered source that is active raises the fault
  assert_any_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_v & src_enable) != '0) |=> fault_active);
endmodule

// File: tb/pwm_fault_timer_test.sv
module pwm_fault_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOADV = 9;
  localparam int CMPV  = 4;
  localparam int NCASE = 8;
  // fields: source[10:8], polarity[7], entry[6:5], exit[4:3], out[2:0]
  localparam logic [10:0] CASES [NCASE] = '{
    {3'd0, 1'b0, 2'd0, 2'd0, 3'd0},
    {3'd1, 1'b1, 2'd1, 2'd1, 3'd1},
    {3'd2, 1'b0, 2'd2, 2'd2, 3'd2},
    {3'd3, 1'b1, 2'd0, 2'd2, 3'd3},
    {3'd5, 1'b0, 2'd1, 2'd0, 3'd4},
    {3'd4, 1'b0, 2'd2, 2'd1, 3'd4},
    {3'd4, 1'b1, 2'd0, 2'd0, 3'd0},
    {3'd5, 1'b1, 2'd2, 2'd0, 3'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] raw_v = '0;
  logic [5:0] src_enable = '0;
  logic [5:0] src_polarity = '0;
  logic [2:0] filt_len = '0;
  logic [7:0] load_val = 8'(LOADV);
  logic [7:0] cmp_val = 8'(CMPV);
  logic [1:0] entry_mode = '0;
  logic [1:0] exit_mode = '0;
  logic [2:0] out_mode = '0;
  logic [7:0] count_out;
  logic       pwm_out;
  logic       pwm_oe;
  logic       fault_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fault_timer uut (
    .clk(clk), .rst_n(rst_n),
    .cmp_in(raw_v[0]), .ext_fault_in(raw_v[3:1]),
    .clkfail_in(raw_v[4]), .evt_trig_in(raw_v[5]),
    .src_enable(src_enable), .src_polarity(src_polarity),
    .filt_len(filt_len), .load_val(load_val), .cmp_val(cmp_val),
    .entry_mode(entry_mode), .exit_mode(exit_mode), .out_mode(out_mode),
    .count_out(count_out), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .fault_active(fault_active)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nstep(input int c);
    return (c == 0) ? LOADV : c - 1;
  endfunction

  function automatic int fstep(input int c, input int e);
    if (e == 0) return c;
    if (e == 1) return (c == 0) ? 0 : c - 1;
    return nstep(c);
  endfunction

  function automatic int xstep(input int c, input int x);
    if (x == 0) return LOADV;
    if (x == 1) return 0;
    return nstep(c);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 count", int'(count_out), 0);
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 oe", int'(pwm_oe), 1);
    chk("R1 fault", int'(fault_active), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input logic [10:0] cv);
    int src, pol, ent, ext, om, c_pre, lvl_pre, exp, eoe;
    src = int'(cv[10:8]); pol = int'(cv[7]); ent = int'(cv[6:5]);
    ext = int'(cv[4:3]); om = int'(cv[2:0]);
    filt_len = '0;
    entry_mode = 2'(ent); exit_mode = 2'(ext); out_mode = 3'(om);
    src_enable = 6'(1 << src);
    src_polarity = 6'(pol << src);
    raw_v = src_polarity;
    do_reset();
    repeat (5) step();
    raw_v[src] = ~pol[0];
    step(); step();
    c_pre = int'(count_out);
    lvl_pre = int'(pwm_out);
    step();
    exp = fstep(c_pre, ent);
    eoe = (om == 3 || src == 4) ? 0 : 1;
    chk("R5 entry latency", int'(fault_active), 1);
    chk("R6 entry count", int'(count_out), exp);
    chk("R8/R9 oe", int'(pwm_oe), eoe);
    for (int k = 0; k < 12; k++) begin
      if (k > 0) step();
      if (k > 0) exp = fstep(exp, ent);
      case (om)
        0: chk("R8 high", int'(pwm_out), 1);
        1: chk("R8 low", int'(pwm_out), 0);
        2: chk("R8 toggle", int'(pwm_out), 1 - lvl_pre);
        4: chk("R8 pwm", int'(pwm_out), int'(count_out < 8'(CMPV)));
        default: chk("R8 hiz", int'(pwm_oe), 0);
      endcase
    end
    chk("R6 held count", int'(count_out), exp);
    chk("R9 oe held", int'(pwm_oe), eoe);
    raw_v[src] = pol[0];
    step(); exp = fstep(exp, ent);
    step(); exp = fstep(exp, ent);
    chk("R10 still fault", int'(fault_active), 1);
    step(); exp = xstep(exp, ext);
    chk("R10 exit flag", int'(fault_active), 0);
    chk("R7 exit count", int'(count_out), exp);
    chk("R10 pwm resumes", int'(pwm_out), int'(count_out < 8'(CMPV)));
    chk("R10 oe resumes", int'(pwm_oe), 1);
  endtask

  initial begin
    int exp, n;
    bit bad;
    // R2: plain counting and PWM level
    src_enable = '0;
    do_reset();
    exp = 0;
    bad = 1'b0;
    for (int k = 0; k < 25; k++) begin
      step();
      exp = nstep(exp);
      if (int'(count_out) != exp || pwm_out != (exp < CMPV)) bad = 1'b1;
    end
    chk("R2 count/pwm", int'(bad), 0);
    chk("R2 count", int'(count_out), exp);

    // table of fault scenarios (R3 R4 R6 R7 R8 R9 R10)
    for (int i = 0; i < NCASE; i++) run_case(CASES[i]);

    // R3: disabled sources ignored, including clock failure
    src_enable = 6'b000010; src_polarity = '0; raw_v = '0;
    out_mode = 3'd0; entry_mode = 2'd0; filt_len = '0;
    do_reset();
    raw_v = 6'b111101;
    exp = 0; bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      step();
      exp = nstep(exp);
      if (fault_active || !pwm_oe || int'(count_out) != exp ||
          pwm_out != (exp < CMPV)) bad = 1'b1;
    end
    chk("R3 disabled ignored", int'(bad), 0);

    // R4: active-low source held high never faults
    raw_v = 6'b000010; src_polarity = 6'b000010;
    do_reset();
    repeat (8) step();
    chk("R4 active-low idle", int'(fault_active), 0);
    raw_v = '0;
    repeat (3) step();
    chk("R4 active-low fault", int'(fault_active), 1);

    // R10: single filtered cycle still enters and exits
    src_enable = 6'b000001; src_polarity = '0; raw_v = '0;
    entry_mode = 2'd0; exit_mode = 2'd0; out_mode = 3'd0; filt_len = '0;
    do_reset();
    repeat (4) step();
    raw_v[0] = 1'b1;
    step();
    raw_v[0] = 1'b0;
    step();
    n = int'(count_out);
    step();
    chk("R10 short entry flag", int'(fault_active), 1);
    chk("R10 short entry hold", int'(count_out), n);
    chk("R10 short entry pin", int'(pwm_out), 1);
    step();
    chk("R10 short exit flag", int'(fault_active), 0);
    chk("R10 short exit reload", int'(count_out), LOADV);
    chk("R10 short exit pin", int'(pwm_out), int'(LOADV < CMPV));

    // R5: filter length 3 rejects a 3-clock pulse, accepts a held level
    filt_len = 3'd3;
    do_reset();
    repeat (3) step();
    raw_v[0] = 1'b1;
    repeat (3) step();
    raw_v[0] = 1'b0;
    bad = 1'b0;
    for (int k = 0; k < 10; k++) begin
      step();
      if (fault_active) bad = 1'b1;
    end
    chk("R5 short pulse rejected", int'(bad), 0);
    raw_v[0] = 1'b1;
    n = 0;
    while (!fault_active && n < 20) begin
      step();
      n++;
    end
    chk("R5 accept latency", n, 3 + 3);
    raw_v[0] = 1'b0;
    repeat (8) step();
    chk("R5 release", int'(fault_active), 0);

    // R11: OR of sources
    filt_len = '0; src_enable = 6'b000101; entry_mode = 2'd2;
    do_reset();
    raw_v = 6'b000101;
    repeat (5) step();
    chk("R11 both", int'(fault_active), 1);
    raw_v = 6'b000100;
    repeat (5) step();
    chk("R11 one left", int'(fault_active), 1);
    raw_v = '0;
    repeat (3) step();
    chk("R11 none left", int'(fault_active), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule